// File: doc/BRIEF.md
# Programmable Down Counter with Terminal-Count Flag

This block is a loadable binary down counter meant for interval timers and programmable clock dividers. On every rising clock edge it steps its value down by one while its active-low count enable is asserted, and it raises nothing but a single active-low flag when the value sits at zero with counting enabled. At zero the next counting edge wraps to the all-ones value, so an undisturbed counter repeats every 2^N clocks.

Four active-low controls steer it. Ranked strongest first, they are:
- clear, which forces all ones at once;
- asynchronous load, which forces the preset word at once and keeps the visible count equal to that word while held;
- synchronous load, which takes the preset word at the next edge even while counting is disabled;
- count enable.

The counter is built as a chain of equal slices. Each slice's enable comes from the flag of the slice below it, the same way separate counters are cascaded on a board. The whole chain therefore behaves as one counter that is WIDTH*STAGES bits wide, and the flag of the last slice is the flag of the chain.

Top module: `dcnt_top`

## Requirements
- R1: With all three load/clear controls high and `cnt_en_n` low, each rising clock edge lowers `count` by one, modulo 2^(WIDTH*STAGES).
- R2: With `cnt_en_n` high and all three load/clear controls high, `count` holds its value across clock edges.
- R3: `term_n` is 0 exactly when `count` is zero and `cnt_en_n` is 0, in the same cycle. Under continued counting it is low for only one clock period.
- R4: With `sync_load_n` low (clear and asynchronous load high), the next rising edge loads `preset` whatever `cnt_en_n` is.
- R5: While `async_load_n` is low (clear high), `count` equals `preset` at once and follows it without a clock edge. This overrides `sync_load_n`, `cnt_en_n` and the clock. After release, the loaded value is kept.
- R6: While `clear_n` is low, `count` is all ones at once, whatever every other input is.
- R7: At zero with counting enabled and no load or clear active, the next edge wraps `count` to all ones. A full cycle from zero back to zero takes 2^(WIDTH*STAGES) edges, with one `term_n` low period.
- R8: Slice k counts only when slice k-1 is at zero and enabled. So the chain borrows like a single binary counter, and `term_n` stays high while any slice is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| cnt_en_n | input | 1 | Count enable, active low |
| sync_load_n | input | 1 | Load preset at next edge, active low |
| async_load_n | input | 1 | Force preset immediately, active low |
| clear_n | input | 1 | Force all ones immediately, active low |
| preset | input | WIDTH*STAGES | Preset word |
| count | output | WIDTH*STAGES | Current count |
| term_n | output | 1 | Terminal count flag, active low |

## Verification
The bench builds the block with WIDTH=4 and STAGES=2. This gives an 8-bit counter made of two cascaded slices, so borrows between slices (0x10 to 0x0F) and a full 256-edge cycle are both within reach in a short run. Every one of the sixteen combinations of the four controls is applied from a known state. The count is checked both before and after the edge, which separates the immediate controls from the edge-timed ones.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

  // Action a slice takes at the next rising edge when neither
  // immediate control is active.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_DEC   = 2'd1,
    ACT_SLOAD = 2'd2
  } act_e;

endpackage

// File: rtl/dcnt_ctrl.sv
module dcnt_ctrl
  import dcnt_pkg::*;
(
  input  logic sync_load_n,
  input  logic en_n,
  output act_e act
);

  // Synchronous load outranks counting.
  always_comb begin
    if (!sync_load_n)  act = ACT_SLOAD;
    else if (!en_n)    act = ACT_DEC;
    else               act = ACT_HOLD;
  end

endmodule

// File: rtl/dcnt_stage.sv
module dcnt_stage
  import dcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             async_load_n,
  input  act_e             act,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;

  // Clear and asynchronous load are immediate terms ahead of the clock.
  always_ff @(posedge clk or negedge clear_n or negedge async_load_n) begin
    if (!clear_n) begin
      cnt_q <= ALL_ONES;
    end else if (!async_load_n) begin
      cnt_q <= preset;
    end else begin
      case (act)
        ACT_SLOAD: cnt_q <= preset;
        ACT_DEC:   cnt_q <= cnt_q - ONE;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  // Bypass so the visible count tracks the preset word while the load is held.
  always_comb begin
    if (!clear_n)           count = ALL_ONES;
    else if (!async_load_n) count = preset;
    else                    count = cnt_q;
  end

endmodule

// File: rtl/dcnt_tc.sv
module dcnt_tc #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] count,
  input  logic             en_n,
  output logic             tc_n
);

  always_comb tc_n = !((count == '0) && !en_n);

endmodule

// File: rtl/dcnt_top.sv
module dcnt_top
  import dcnt_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int STAGES = 1,
  localparam int CW    = WIDTH * STAGES
) (
  input  logic          clk,
  input  logic          cnt_en_n,
  input  logic          sync_load_n,
  input  logic          async_load_n,
  input  logic          clear_n,
  input  logic [CW-1:0] preset,
  output logic [CW-1:0] count,
  output logic          term_n
);

  // en_chain[k] enables slice k; en_chain[k+1] is the flag of slice k.
  logic [STAGES:0] en_chain;
  assign en_chain[0] = cnt_en_n;

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_slice
      act_e             act;
      logic [WIDTH-1:0] slice_cnt;

      dcnt_ctrl u_ctrl (
        .sync_load_n (sync_load_n),
        .en_n        (en_chain[k]),
        .act         (act)
      );

      dcnt_stage #(.WIDTH(WIDTH)) u_stage (
        .clk          (clk),
        .clear_n      (clear_n),
        .async_load_n (async_load_n),
        .act          (act),
        .preset       (preset[k*WIDTH +: WIDTH]),
        .count        (slice_cnt)
      );

      dcnt_tc #(.WIDTH(WIDTH)) u_tc (
        .count (slice_cnt),
        .en_n  (en_chain[k]),
        .tc_n  (en_chain[k+1])
      );

      assign count[k*WIDTH +: WIDTH] = slice_cnt;
    end
  endgenerate

  assign term_n = en_chain[STAGES];

endmodule

// File: rtl/dcnt_chk.sv
module dcnt_chk #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 1,
  localparam int CW    = WIDTH * STAGES
) (
  input logic          clk,
  input logic          cnt_en_n,
  input logic          sync_load_n,
  input logic          async_load_n,
  input logic          clear_n,
  input logic [CW-1:0] preset,
  input logic [CW-1:0] count,
  input logic          term_n
);

  localparam logic [CW-1:0] ALL_ONES = '1;
  localparam logic [CW-1:0] ONE      = CW'(1);

  assert_decrement_R1: assert property (@(posedge clk)
    disable iff (!clear_n || !async_load_n)
    (sync_load_n && !cnt_en_n) |=> (count == $past(count) - ONE));

  assert_hold_R2: assert property (@(posedge clk)
    disable iff (!clear_n || !async_load_n)
    (sync_load_n && cnt_en_n) |=> (count == $past(count)));

  assert_flag_zero_R3: assert property (@(posedge clk)
    disable iff (!clear_n)
    !term_n |-> (count == '0 && !cnt_en_n));

  assert_flag_single_R3: assert property (@(posedge clk)
    disable iff (!clear_n || !async_load_n)
    (!term_n && sync_load_n) |=> term_n);

  assert_sync_load_R4: assert property (@(posedge clk)
    disable iff (!clear_n || !async_load_n)
    !sync_load_n |=> (count == $past(preset)));

  // R5 and R6: immediate controls override the clock.
  always @(posedge clk) begin
    if (clear_n === 1'b1 && async_load_n === 1'b0)
      assert_async_load_R5: assert (count == preset);
    if (clear_n === 1'b0)
      assert_clear_R6: assert (count == ALL_ONES);
  end

endmodule

bind dcnt_top dcnt_chk #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chk (
  .clk          (clk),
  .cnt_en_n     (cnt_en_n),
  .sync_load_n  (sync_load_n),
  .async_load_n (async_load_n),
  .clear_n      (clear_n),
  .preset       (preset),
  .count        (count),
  .term_n       (term_n)
);

// File: tb/dcnt_top_tb.sv
module dcnt_top_tb;

  localparam int W  = 4;
  localparam int S  = 2;
  localparam int CW = W * S;

  logic          clk = 1'b0;
  logic          cnt_en_n = 1'b1, sync_load_n = 1'b1, async_load_n = 1'b1, clear_n = 1'b0;
  logic [CW-1:0] preset = '0;
  logic [CW-1:0] count;
  logic          term_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dcnt_top #(.WIDTH(W), .STAGES(S)) u_dut (
    .clk (clk), .cnt_en_n (cnt_en_n), .sync_load_n (sync_load_n),
    .async_load_n (async_load_n), .clear_n (clear_n), .preset (preset),
    .count (count), .term_n (term_n)
  );

  // Fields: clear, aload, sload, en (all active low), preset, expected count, expected flag.
  localparam logic [20:0] VEC [0:16] = '{
    {4'b0111, 8'h00, 8'hFF, 1'b1},  // R6 clear
    {4'b1101, 8'h03, 8'h03, 1'b1},  // R4 load with enable off
    {4'b1110, 8'h00, 8'h02, 1'b1},  // R1
    {4'b1110, 8'h00, 8'h01, 1'b1},  // R1
    {4'b1110, 8'h00, 8'h00, 1'b0},  // R3 flag at zero
    {4'b1110, 8'h00, 8'hFF, 1'b1},  // R7 wrap
    {4'b1111, 8'h00, 8'hFF, 1'b1},  // R2 hold
    {4'b1101, 8'h10, 8'h10, 1'b1},  // R4
    {4'b1110, 8'h00, 8'h0F, 1'b1},  // R8 borrow across slices
    {4'b1100, 8'h5A, 8'h5A, 1'b1},  // R4 over counting
    {4'b1000, 8'h33, 8'h33, 1'b1},  // R5 over sync load
    {4'b0000, 8'h44, 8'hFF, 1'b1},  // R6 over all
    {4'b1110, 8'h00, 8'hFE, 1'b1},  // R1 after clear
    {4'b1010, 8'h00, 8'h00, 1'b0},  // R5 zero loaded, R3 flag
    {4'b1011, 8'h00, 8'h00, 1'b1},  // R3 gated by enable
    {4'b1111, 8'h00, 8'h00, 1'b1},  // R5 kept after release
    {4'b1110, 8'h00, 8'hFF, 1'b1}   // R7 wrap
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] ctl, input logic [CW-1:0] p);
    {clear_n, async_load_n, sync_load_n, cnt_en_n} = ctl;
    preset = p;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int lows;
    // Reset state through clear.
    @(negedge clk);
    #1 chk("R6 reset count", int'(count), 8'hFF);
    chk("R3 reset flag", int'(term_n), 1);

    // Vector table.
    for (int i = 0; i < 17; i++) begin
      @(negedge clk);
      drive(VEC[i][20:17], VEC[i][16:9]);
      @(posedge clk);
      #1;
      chk($sformatf("vec%0d count R1/R2/R4/R5/R6/R7/R8", i), int'(count), int'(VEC[i][8:1]));
      chk($sformatf("vec%0d flag R3", i), int'(term_n), int'(VEC[i][0]));
    end

    // Priority over every combination of the four controls.
    for (int c = 0; c < 16; c++) begin
      logic [3:0] ctl;
      int exp_now, exp_after;
      ctl = 4'(c);
      @(negedge clk);
      drive(4'b1101, 8'h80);
      @(negedge clk);
      drive(ctl, 8'h21);
      exp_now   = !ctl[3] ? 8'hFF : !ctl[2] ? 8'h21 : 8'h80;
      exp_after = !ctl[3] ? 8'hFF : (!ctl[2] || !ctl[1]) ? 8'h21 : !ctl[0] ? 8'h7F : 8'h80;
      #1 chk($sformatf("R6/R5 priority now ctl=%b", ctl), int'(count), exp_now);
      @(posedge clk);
      #1 chk($sformatf("R6/R5/R4/R1 priority edge ctl=%b", ctl), int'(count), exp_after);
    end

    // Asynchronous load follows the preset without a clock edge.
    @(negedge clk);
    drive(4'b1011, 8'h12);
    #0.5 chk("R5 immediate", int'(count), 8'h12);
    preset = 8'h34;
    #0.5 chk("R5 follows preset", int'(count), 8'h34);
    @(negedge clk);
    drive(4'b1111, 8'h00);
    @(posedge clk);
    #1 chk("R5 kept after release", int'(count), 8'h34);

    // Cascade: low slice zero but high slice not, flag stays high.
    @(negedge clk);
    drive(4'b1101, 8'h10);
    @(negedge clk);
    drive(4'b1110, 8'h00);
    #0.5 chk("R8 flag high with upper slice nonzero", int'(term_n), 1);

    // Full cycle from zero.
    @(negedge clk);
    drive(4'b1101, 8'h00);
    @(negedge clk);
    drive(4'b1110, 8'h00);
    #0.5 chk("R3 flag at start of cycle", int'(term_n), 0);
    lows = 0;
    for (int e = 0; e < 256; e++) begin
      @(posedge clk);
      #1;
      if (e == 0) chk("R7 first wrap", int'(count), 8'hFF);
      if (!term_n) lows++;
    end
    chk("R7 back at zero after 256 edges", int'(count), 8'h00);
    chk("R7 single flag period", lows, 1);
    chk("R3 flag low at end", int'(term_n), 0);

    done = 1'b1;
    finish_run();
  end

endmodule